// File: doc/BRIEF.md
# Four-Channel Sample Queue with Per-Channel Interrupts

This block sits between four converter channels and a processor bus. Each channel delivers samples through a one-cycle valid strobe, and each channel has its own four-entry queue. The block accepts a sample only while the global run bit is set and the channel's capture bit is set. Software empties a queue by reading that channel's data word, and it reads the channel's fill count from a level word. A channel that has DMA enabled requests service for as long as its queue holds data.

Each channel records four events in a status word: overflow, underflow, empty and full. Overflow is a sample that arrives while the queue is full. Underflow is a data read while the queue is empty. Empty and full are set on the cycle the queue enters that state. Software clears status bits by writing ones to them. A per-channel enable word selects which status bits drive that channel's interrupt line.

Top module: `smpq_irq_unit`

## Requirements
- R1: A channel stores a sample only if the global run bit (bit 0 at word 0x00) is 1 and its capture bit is 1. The capture bits are at word 0x01, bit c+1 for channel c. Bit 0 of word 0x01 has no effect.
- R2: Each queue holds 4 samples and returns them first in, first out. Reading word 0x10+c returns the oldest sample in the low 14 bits and removes it. Word 0x0C+c returns the fill count, 0 to 4, in bits 2:0.
- R3: A sample that arrives while the queue holds 4 entries is dropped, the level stays at 4, and status bit 0 (overflow) is set.
- R4: A data read while the queue is empty returns the last sample removed, leaves the level at 0, and sets status bit 1 (underflow).
- R5: Status bit 2 (empty) is set on the cycle the level falls to 0. Status bit 3 (full) is set on the cycle the level reaches 4. Neither is set by reset.
- R6: The status word for channel c is at word 0x08+c. Writing a 1 to a bit clears that bit, and writing a 0 leaves it unchanged. If an event sets a bit in the same cycle that a write clears it, the bit ends up set.
- R7: The interrupt enable word for channel c is at word 0x04+c and uses the same bit order as the status word. irq[c] is 1 exactly when an enabled status bit is 1. Status bits that are not enabled do not drive the line.
- R8: The DMA enable bits are at word 0x02, bit 2c for channel c. dma_req[c] is 1 while that bit is 1 and the channel's level is not zero. The odd bits of word 0x02 have no effect.
- R9: Reads return only the implemented bits: bit 0 at word 0x00, bits 1-4 at word 0x01, and bits 0, 2, 4 and 6 at word 0x02. Unmapped words read as 0.
- R10: After reset all control, enable, status and level words read 0, and irq and dma_req are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | NCH | Sample strobe, one bit per channel |
| smp_data | input | NCH*SMP_W | Sample values; channel c occupies slice c |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe; removes a sample when it addresses a data word |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| irq | output | NCH | Per-channel interrupt |
| dma_req | output | NCH | Per-channel DMA request |

## Verification
The bench targets the queue boundaries. It pushes a fifth sample into a full queue: a faulty design would overwrite the oldest entry or let the level wrap to zero. It reads an empty queue: a faulty design would return stale memory instead of the last sample removed, or let the level go negative. It clears a status bit with a write in the same cycle that an event sets it: a faulty design would lose the overflow. It also checks the scattered positions of the capture and DMA bits: a design that packed them together would capture on the wrong channel or raise a request from an odd bit.

// File: rtl/smpq_pkg.sv
package smpq_pkg;
  localparam int FLG_OVF = 0;
  localparam int FLG_UDF = 1;
  localparam int FLG_EMP = 2;
  localparam int FLG_FUL = 3;
  localparam int NFLG    = 4;
  localparam int ADDR_W  = 6;

  localparam logic [ADDR_W-1:0] A_RUN   = 6'h00;
  localparam logic [ADDR_W-1:0] A_CAP   = 6'h01;
  localparam logic [ADDR_W-1:0] A_DMA   = 6'h02;
  localparam logic [ADDR_W-1:0] A_IEN0  = 6'h04;
  localparam logic [ADDR_W-1:0] A_STAT0 = 6'h08;
  localparam logic [ADDR_W-1:0] A_LVL0  = 6'h0C;
  localparam logic [ADDR_W-1:0] A_DATA0 = 6'h10;

  // capture bits are shifted up by one, bit 0 stays empty
  function automatic int cap_bit(int ch);
    return ch + 1;
  endfunction

  // DMA bits occupy every second position
  function automatic int dma_bit(int ch);
    return 2 * ch;
  endfunction

  function automatic logic [ADDR_W-1:0] ch_word(logic [ADDR_W-1:0] base, int ch);
    return base + ADDR_W'(ch);
  endfunction
endpackage

// File: rtl/smpq_chan_fifo.sv
module smpq_chan_fifo #(
  parameter int DEPTH = 4,
  parameter int SMP_W = 14,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [SMP_W-1:0] push_data,
  input  logic             pop,
  output logic [SMP_W-1:0] rd_data,
  output logic [LVL_W-1:0] level,
  output logic             ovf_evt,
  output logic             udf_evt,
  output logic             emp_evt,
  output logic             ful_evt
);
  logic [SMP_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [LVL_W-1:0] cnt, cnt_nxt;
  logic [SMP_W-1:0] last_q;
  logic is_full, is_empty, do_push, do_pop;

  function automatic logic [PTR_W-1:0] step(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign is_full  = (cnt == LVL_W'(DEPTH));
  assign is_empty = (cnt == '0);
  assign do_push  = push && !is_full;
  assign do_pop   = pop && !is_empty;
  assign ovf_evt  = push && is_full;
  assign udf_evt  = pop && is_empty;
  assign cnt_nxt  = cnt + LVL_W'(do_push) - LVL_W'(do_pop);
  assign emp_evt  = !is_empty && (cnt_nxt == '0);
  assign ful_evt  = !is_full && (cnt_nxt == LVL_W'(DEPTH));
  assign rd_data  = is_empty ? last_q : mem[rd_ptr];
  assign level    = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      last_q <= '0;
    end else begin
      cnt <= cnt_nxt;
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop) begin
        rd_ptr <= step(rd_ptr);
        last_q <= mem[rd_ptr];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end
endmodule

// File: rtl/smpq_chan_status.sv
module smpq_chan_status
  import smpq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NFLG-1:0] evt,
  input  logic            clr_we,
  input  logic [NFLG-1:0] clr_mask,
  input  logic            ien_we,
  input  logic [NFLG-1:0] ien_wdata,
  output logic [NFLG-1:0] stat,
  output logic [NFLG-1:0] ien,
  output logic            irq
);
  logic [NFLG-1:0] clr_eff;

  assign clr_eff = clr_we ? clr_mask : '0;
  assign irq     = |(stat & ien);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0;
      ien  <= '0;
    end else begin
      stat <= (stat & ~clr_eff) | evt;
      if (ien_we) ien <= ien_wdata;
    end
  end
endmodule

// File: rtl/smpq_irq_unit.sv
module smpq_irq_unit
  import smpq_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int DEPTH  = 4,
  parameter int SMP_W  = 14,
  parameter int DATA_W = 32,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH-1:0]        smp_valid,
  input  logic [NCH*SMP_W-1:0]  smp_data,
  input  logic                  bus_we,
  input  logic                  bus_re,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic [NCH-1:0]        irq,
  output logic [NCH-1:0]        dma_req
);
  logic                             run_q;
  logic [NCH-1:0]                   cap_q, dmaen_q;
  logic [NCH-1:0]                   push_w, pop_w, ovf_evt_w, udf_evt_w;
  logic [NCH-1:0][LVL_W-1:0]        lvl_all;
  logic [NCH-1:0][NFLG-1:0]         stat_all, ien_all;
  logic [NCH-1:0][SMP_W-1:0]        dout_all;
  logic                             unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      cap_q   <= '0;
      dmaen_q <= '0;
    end else if (bus_we) begin
      if (bus_addr == A_RUN) run_q <= bus_wdata[0];
      for (int c = 0; c < NCH; c++) begin
        if (bus_addr == A_CAP) cap_q[c]   <= bus_wdata[cap_bit(c)];
        if (bus_addr == A_DMA) dmaen_q[c] <= bus_wdata[dma_bit(c)];
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic emp_e, ful_e;
    assign push_w[c]  = smp_valid[c] && run_q && cap_q[c];
    assign pop_w[c]   = bus_re && (bus_addr == ch_word(A_DATA0, c));
    assign dma_req[c] = dmaen_q[c] && (lvl_all[c] != '0);

    smpq_chan_fifo #(.DEPTH(DEPTH), .SMP_W(SMP_W)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (push_w[c]),
      .push_data(smp_data[c*SMP_W +: SMP_W]),
      .pop      (pop_w[c]),
      .rd_data  (dout_all[c]),
      .level    (lvl_all[c]),
      .ovf_evt  (ovf_evt_w[c]),
      .udf_evt  (udf_evt_w[c]),
      .emp_evt  (emp_e),
      .ful_evt  (ful_e)
    );

    smpq_chan_status u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      ({ful_e, emp_e, udf_evt_w[c], ovf_evt_w[c]}),
      .clr_we   (bus_we && (bus_addr == ch_word(A_STAT0, c))),
      .clr_mask (bus_wdata[NFLG-1:0]),
      .ien_we   (bus_we && (bus_addr == ch_word(A_IEN0, c))),
      .ien_wdata(bus_wdata[NFLG-1:0]),
      .stat     (stat_all[c]),
      .ien      (ien_all[c]),
      .irq      (irq[c])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_RUN) bus_rdata[0] = run_q;
    for (int c = 0; c < NCH; c++) begin
      if (bus_addr == A_CAP) bus_rdata[cap_bit(c)] = cap_q[c];
      if (bus_addr == A_DMA) bus_rdata[dma_bit(c)] = dmaen_q[c];
      if (bus_addr == ch_word(A_IEN0, c))  bus_rdata[NFLG-1:0]  = ien_all[c];
      if (bus_addr == ch_word(A_STAT0, c)) bus_rdata[NFLG-1:0]  = stat_all[c];
      if (bus_addr == ch_word(A_LVL0, c))  bus_rdata[LVL_W-1:0] = lvl_all[c];
      if (bus_addr == ch_word(A_DATA0, c)) bus_rdata[SMP_W-1:0] = dout_all[c];
    end
  end
endmodule

// File: rtl/smpq_irq_unit_chk.sv
module smpq_irq_unit_chk
  import smpq_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int DEPTH = 4,
  parameter int LVL_W = 3
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      run_q,
  input logic [NCH-1:0][LVL_W-1:0] lvl_all,
  input logic [NCH-1:0][NFLG-1:0]  stat_all,
  input logic [NCH-1:0]            ovf_evt_w,
  input logic [NCH-1:0]            udf_evt_w
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_all[c] <= LVL_W'(DEPTH));
    assert_ovf_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt_w[c] |=> stat_all[c][FLG_OVF]);
    assert_ovf_keeps_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt_w[c] |=> (lvl_all[c] == LVL_W'(DEPTH)) || (lvl_all[c] == LVL_W'(DEPTH - 1)));
    assert_udf_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
      udf_evt_w[c] |=> stat_all[c][FLG_UDF]);
    assert_full_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_all[c][FLG_FUL]) |-> (lvl_all[c] == LVL_W'(DEPTH)));
    assert_empty_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_all[c][FLG_EMP]) |-> (lvl_all[c] == '0));
    assert_no_growth_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |=> (lvl_all[c] <= $past(lvl_all[c])));
  end
endmodule

bind smpq_irq_unit smpq_irq_unit_chk #(.NCH(NCH), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run_q    (run_q),
  .lvl_all  (lvl_all),
  .stat_all (stat_all),
  .ovf_evt_w(ovf_evt_w),
  .udf_evt_w(udf_evt_w)
);

// File: tb/test_smpq_irq_unit.sv
`timescale 1ns/1ps
module test_smpq_irq_unit;
  localparam int NCH = 4, SMP_W = 14, DW = 32;
  localparam logic [5:0] W_RUN = 6'h00, W_CAP = 6'h01, W_DMA = 6'h02;
  localparam logic [5:0] W_IEN = 6'h04, W_STAT = 6'h08, W_LVL = 6'h0C, W_DATA = 6'h10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NCH-1:0] smp_valid = '0;
  logic [NCH*SMP_W-1:0] smp_data = '0;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [NCH-1:0] irq, dma_req;

  int checks = 0, failures = 0;
  int exp_q[$];

  always #2.5 clk = ~clk;

  smpq_irq_unit i_smpq_irq_unit (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .dma_req(dma_req)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [5:0] a, input int exp, input string req);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(bus_rdata == DW'(exp), req, int'(bus_rdata), exp);
  endtask

  // driver: a sample that the model expects to be stored enters the scoreboard
  task automatic push(input int ch, input int v, input bit stored);
    @(negedge clk);
    smp_valid[ch] = 1'b1;
    smp_data[ch*SMP_W +: SMP_W] = SMP_W'(v);
    @(negedge clk);
    smp_valid = '0;
    if (stored) exp_q.push_back(v);
  endtask

  // monitor: each removed sample is compared against the scoreboard head
  task automatic pop(input int ch, input string req);
    int exp;
    @(negedge clk);
    bus_addr = W_DATA + 6'(ch); bus_re = 1'b1;
    #1;
    exp = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
    check(int'(bus_rdata[SMP_W-1:0]) == exp, req, int'(bus_rdata[SMP_W-1:0]), exp);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic port_chk(input logic [NCH-1:0] act, input logic [NCH-1:0] exp, input string req);
    @(negedge clk);
    #1;
    check(act == exp, req, int'(act), int'(exp));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL R10 watchdog actual=timeout expected=completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R10 reset state
    rd_chk(W_RUN, 0, "R10 run word");
    rd_chk(W_CAP, 0, "R10 capture word");
    rd_chk(W_DMA, 0, "R10 dma word");
    rd_chk(W_STAT + 6'd1, 0, "R10 status ch1");
    rd_chk(W_LVL, 0, "R10 level ch0");
    port_chk(irq, 4'b0000, "R10 irq");
    port_chk(dma_req, 4'b0000, "R10 dma_req");

    // R1 capture gating
    wr(W_CAP, 32'h02);
    push(0, 'h11, 0);
    rd_chk(W_LVL, 0, "R1 run bit clear blocks capture");
    wr(W_RUN, 32'h1);
    push(1, 'h22, 0);
    rd_chk(W_LVL + 6'd1, 0, "R1 channel 1 not enabled");
    wr(W_CAP, 32'h01);
    push(0, 'h12, 0);
    rd_chk(W_LVL, 0, "R1 bit 0 of capture word ignored");
    wr(W_CAP, 32'h1E);
    push(0, 'h33, 1);
    rd_chk(W_LVL, 1, "R1 channel 0 captures at bit 1");

    // R9 readback masks
    wr(W_CAP, 32'hFF);
    rd_chk(W_CAP, 'h1E, "R9 capture readback");
    wr(W_CAP, 32'h1E);
    wr(W_RUN, 32'hFF);
    rd_chk(W_RUN, 1, "R9 run readback");
    wr(W_DMA, 32'hFF);
    rd_chk(W_DMA, 'h55, "R9 dma readback");
    rd_chk(6'h03, 0, "R9 unmapped word");

    // R8 DMA requests
    wr(W_DMA, 32'h02);
    port_chk(dma_req, 4'b0000, "R8 odd bit has no effect");
    wr(W_DMA, 32'h01);
    port_chk(dma_req, 4'b0001, "R8 request with data");
    pop(0, "R2 ch0 sample");
    port_chk(dma_req, 4'b0000, "R8 request drops when empty");
    rd_chk(W_STAT, 'h4, "R5 empty on last removal");

    // R2 R3 R5 on channel 1
    for (int i = 0; i < 4; i++) push(1, 'h100 + i, 1);
    rd_chk(W_LVL + 6'd1, 4, "R2 level four");
    rd_chk(W_STAT + 6'd1, 'h8, "R5 full on reaching four");
    port_chk(irq, 4'b0000, "R7 status bits not enabled");
    push(1, 'h104, 0);
    rd_chk(W_LVL + 6'd1, 4, "R3 level stays at four");
    rd_chk(W_STAT + 6'd1, 'h9, "R3 overflow set");
    for (int i = 0; i < 4; i++) pop(1, "R2 order ch1");
    rd_chk(W_STAT + 6'd1, 'hD, "R5 empty after draining");

    // R4 underflow
    exp_q.push_back('h103);
    pop(1, "R4 last value returned");
    rd_chk(W_LVL + 6'd1, 0, "R4 level stays zero");
    rd_chk(W_STAT + 6'd1, 'hF, "R4 underflow set");

    // R6 write-one-to-clear
    wr(W_STAT + 6'd1, 32'h1);
    rd_chk(W_STAT + 6'd1, 'hE, "R6 clear one bit");
    wr(W_STAT + 6'd1, 32'h0);
    rd_chk(W_STAT + 6'd1, 'hE, "R6 zero write no effect");
    wr(W_STAT + 6'd1, 32'hE);
    rd_chk(W_STAT + 6'd1, 0, "R6 clear rest");

    // R7 interrupt gating
    wr(W_IEN + 6'd1, 32'h2);
    rd_chk(W_IEN + 6'd1, 2, "R7 enable readback");
    port_chk(irq, 4'b0000, "R7 no status no irq");
    exp_q.push_back('h103);
    pop(1, "R4 repeated underflow value");
    port_chk(irq, 4'b0010, "R7 enabled underflow raises irq1");
    wr(W_STAT + 6'd1, 32'h2);
    port_chk(irq, 4'b0000, "R7 irq drops after clear");
    wr(W_IEN + 6'd1, 32'h1);
    exp_q.push_back('h103);
    pop(1, "R4 underflow value again");
    port_chk(irq, 4'b0000, "R7 disabled source has no effect");

    // R6 event wins over simultaneous clear, channel 2
    for (int i = 0; i < 4; i++) push(2, 'h200 + i, 0);
    rd_chk(W_STAT + 6'd2, 'h8, "R5 full ch2");
    @(negedge clk);
    smp_valid[2] = 1'b1; smp_data[2*SMP_W +: SMP_W] = 'h2FF;
    bus_we = 1'b1; bus_addr = W_STAT + 6'd2; bus_wdata = 32'h9;
    @(negedge clk);
    smp_valid = '0; bus_we = 1'b0;
    rd_chk(W_STAT + 6'd2, 'h1, "R6 event wins over clear");
    rd_chk(W_LVL + 6'd2, 4, "R3 level held ch2");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule